// File: doc/BRIEF.md
# SMBus Packet Error Code Engine

This block sits next to the byte shifter of an SMBus host controller and handles the packet error code (PEC) byte without software help. The shifter reports each byte it moves on the wire with a one-cycle strobe. Each report carries the byte value and a flag that tells whether the host sent the byte or received it. Framing pulses mark where a transaction starts and where it ends. In hardware-PEC mode the block keeps a running CRC-8 over every byte since the last start pulse, covering both address and data bytes. It offers that CRC as the next byte the shifter should send. When a transaction ends on a received byte, the block checks that byte as the PEC.

Software-PEC mode is the other option. In that mode the block forwards a byte loaded by software and performs no check. A failed read check sets two sticky flags: a general device-error flag and a CRC-specific flag. A third sticky flag records the illegal setting where the software-PEC enable and hardware-PEC mode are both on. Each flag is cleared by its own write-one-to-clear pulse.

Top module: `smb_pec_engine`

## Requirements
- R1: The running CRC is CRC-8 with generator polynomial 0x07 (x^8+x^2+x+1), start value 0x00 and no final inversion, shifted MSB first. It covers every byte strobed with `byte_vld`, whether sent or received. With `auto_en`=1, `pec_out` shows the CRC of all bytes since the last `txn_start`, starting in the cycle after the last byte's strobe (for example, the single byte 0x01 gives 0x07 and 0xFF gives 0xF3).
- R2: A `txn_start` pulse sets the CRC back to 0x00. A byte strobed in the same cycle as `txn_start` counts as the first byte of the new transaction. A `txn_start` pulse with no byte makes `pec_out` read 0x00 in auto mode.
- R3: A change of direction inside a transaction, such as a write-phase address followed by read-phase bytes after a repeated start, does not reset the CRC. Accumulation continues over all the bytes.
- R4: With `auto_en`=0, `pec_out` equals `sw_pec` at all times.
- R5: With `auto_en`=1, `pec_out` does not depend on `sw_pec`. Changing `sw_pec` leaves `pec_out` unchanged.
- R6: With `auto_en`=1, a `txn_end` pulse performs a read check if the final byte of the transaction was received (`byte_rx`=1). A byte strobed in the same cycle as `txn_end` counts as that final byte. The check fails when the CRC over all the bytes, the final byte included, is not 0x00. A failed check sets both `dev_err` and `crc_err` from the next cycle on.
- R7: No check is made, and neither error flag is set, when `auto_en`=0 or when the final byte was sent rather than received.
- R8: `cfg_err` is set from the next cycle on after any clock edge that samples `auto_en`=1 and `sw_pec_en`=1 together. `sw_pec_en` alone never sets it.
- R9: Each status flag stays set until its clear bit is pulsed: `status_clr[0]` clears `dev_err`, `status_clr[1]` clears `crc_err`, `status_clr[2]` clears `cfg_err`. If a set and a clear arrive in the same cycle, the set wins.
- R10: After reset all three flags read 0, and in auto mode `pec_out` reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | Transaction start pulse; clears the CRC |
| txn_end | input | 1 | Transaction end pulse; triggers the read check |
| byte_vld | input | 1 | One byte moved on the bus this cycle |
| byte_rx | input | 1 | 1 = byte received from target, 0 = byte sent by host |
| byte_data | input | 8 | Value of the byte |
| auto_en | input | 1 | Hardware PEC mode enable |
| sw_pec_en | input | 1 | Software PEC enable (illegal together with auto_en) |
| sw_pec | input | 8 | Software-loaded PEC byte |
| status_clr | input | 3 | Write-one-to-clear pulses for dev_err, crc_err, cfg_err |
| pec_out | output | 8 | PEC byte for the shifter to send |
| dev_err | output | 1 | Sticky device-error flag |
| crc_err | output | 1 | Sticky CRC-error flag |
| cfg_err | output | 1 | Sticky illegal-configuration flag |

## Verification
The bench feeds reads whose final byte is, in turn, the correct PEC and a corrupted one. A design that compared against the wrong running value would flag good reads or pass bad ones. It includes reads that change direction with no start pulse, which catches a design that resets the CRC on the repeated start. It also strobes a byte in the same cycle as `txn_start` or `txn_end`, which exposes a design that drops that byte or checks before including it. Finally, it applies a clear and a set in the same cycle, and confirms that a later good read leaves `dev_err` set, so a design with weak sticky logic loses an error.

// File: rtl/smb_pec_pkg.sv
package smb_pec_pkg;
    localparam int unsigned PEC_W    = 8;
    localparam logic [7:0]  PEC_POLY = 8'h07;
    localparam logic [7:0]  PEC_INIT = 8'h00;

    // status flag positions inside the set/clear vectors
    localparam int unsigned ST_DEV = 0;
    localparam int unsigned ST_CRC = 1;
    localparam int unsigned ST_CFG = 2;
    localparam int unsigned ST_N   = 3;
endpackage

// File: rtl/smb_pec_accum.sv
module smb_pec_accum #(
    parameter int unsigned   W    = 8,
    parameter logic [W-1:0]  POLY = 8'h07,
    parameter logic [W-1:0]  INIT = 8'h00
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         finish,
    input  logic         byte_vld,
    input  logic         byte_rx,
    input  logic [W-1:0] byte_data,
    output logic [W-1:0] crc_q,
    output logic         rd_end,
    output logic         residue_bad
);
    typedef struct packed {
        logic [W-1:0] crc;
        logic         any;
        logic         last_rx;
    } acc_t;

    acc_t st_d, st_q, mid;
    logic [W-1:0] work;

    always_comb begin
        mid = st_q;
        if (clear) begin
            mid.crc     = INIT;
            mid.any     = 1'b0;
            mid.last_rx = 1'b0;
        end
        work = mid.crc ^ byte_data;
        for (int k = 0; k < int'(W); k++) begin
            work = work[W-1] ? ((work << 1) ^ POLY) : (work << 1);
        end
        if (byte_vld) begin
            mid.crc     = work;
            mid.any     = 1'b1;
            mid.last_rx = byte_rx;
        end
        rd_end      = finish & mid.any & mid.last_rx;
        residue_bad = (mid.crc != '0);
        st_d        = mid;
        if (finish) begin
            st_d.any = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{crc: INIT, any: 1'b0, last_rx: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign crc_q = st_q.crc;

    // R2
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !byte_vld) |=> (crc_q == INIT));

    // R1
    idle_holds_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !byte_vld) |=> $stable(crc_q));
endmodule

// File: rtl/smb_pec_sticky.sv
module smb_pec_sticky #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] flag_d, flag_q;

    for (genvar i = 0; i < int'(N); i++) begin : g_flag
        always_comb begin
            flag_d[i] = set[i] | (flag_q[i] & ~clr[i]);
        end

        // R9
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr[i]) |=> flags[i]);

        // R9
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flags = flag_q;
endmodule

// File: rtl/smb_pec_engine.sv
module smb_pec_engine
    import smb_pec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txn_start,
    input  logic       txn_end,
    input  logic       byte_vld,
    input  logic       byte_rx,
    input  logic [7:0] byte_data,
    input  logic       auto_en,
    input  logic       sw_pec_en,
    input  logic [7:0] sw_pec,
    input  logic [2:0] status_clr,
    output logic [7:0] pec_out,
    output logic       dev_err,
    output logic       crc_err,
    output logic       cfg_err
);
    logic [PEC_W-1:0] crc_q;
    logic             rd_end;
    logic             residue_bad;
    logic             chk_fail;
    logic [ST_N-1:0]  st_set;
    logic [ST_N-1:0]  st_flags;

    smb_pec_accum #(
        .W    (PEC_W),
        .POLY (PEC_POLY),
        .INIT (PEC_INIT)
    ) accum_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (txn_start),
        .finish      (txn_end),
        .byte_vld    (byte_vld),
        .byte_rx     (byte_rx),
        .byte_data   (byte_data),
        .crc_q       (crc_q),
        .rd_end      (rd_end),
        .residue_bad (residue_bad)
    );

    always_comb begin
        chk_fail       = auto_en & rd_end & residue_bad;
        st_set         = '0;
        st_set[ST_DEV] = chk_fail;
        st_set[ST_CRC] = chk_fail;
        st_set[ST_CFG] = auto_en & sw_pec_en;
    end

    smb_pec_sticky #(
        .N (ST_N)
    ) status_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (st_set),
        .clr   (status_clr),
        .flags (st_flags)
    );

    assign pec_out = auto_en ? crc_q : sw_pec;
    assign dev_err = st_flags[ST_DEV];
    assign crc_err = st_flags[ST_CRC];
    assign cfg_err = st_flags[ST_CFG];

    // R6
    crc_implies_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> dev_err);

    // R6
    crc_needs_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> $past(txn_end));

    // R7
    no_check_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> !$rose(crc_err));

    // R8
    cfg_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && sw_pec_en) |=> cfg_err);
endmodule

// File: tb/smb_pec_engine_tb.sv
module smb_pec_engine_tb_top;
    typedef struct packed {
        logic        auto_m;
        logic [2:0]  nb;
        logic [31:0] bytes;
        logic [3:0]  rxm;
        logic        bad;
        logic [7:0]  sw;
    } vec_t;

    // rxm[i] marks byte i as received; the last received byte is replaced by a PEC
    localparam vec_t VECS [9] = '{
        '{1'b1, 3'd2, 32'hA0130000, 4'b0000, 1'b0, 8'h55},
        '{1'b1, 3'd3, 32'h5A00FF00, 4'b0000, 1'b0, 8'h11},
        '{1'b1, 3'd4, 32'hA0073C00, 4'b1100, 1'b0, 8'h22},
        '{1'b1, 3'd4, 32'hA0073C00, 4'b1100, 1'b1, 8'h22},
        '{1'b0, 3'd2, 32'hA0130000, 4'b0000, 1'b0, 8'hC9},
        '{1'b0, 3'd3, 32'hA1770000, 4'b0110, 1'b1, 8'h3E},
        '{1'b1, 3'd2, 32'h81000000, 4'b0011, 1'b0, 8'h00},
        '{1'b1, 3'd2, 32'h81000000, 4'b0011, 1'b1, 8'h00},
        '{1'b1, 3'd2, 32'h9C420000, 4'b0001, 1'b0, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_start = 1'b0, txn_end = 1'b0, byte_vld = 1'b0, byte_rx = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       auto_en = 1'b0, sw_pec_en = 1'b0;
    logic [7:0] sw_pec = 8'h00;
    logic [2:0] status_clr = 3'b000;
    logic [7:0] pec_out;
    logic       dev_err, crc_err, cfg_err;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    smb_pec_engine dut_i (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_end(txn_end),
        .byte_vld(byte_vld), .byte_rx(byte_rx), .byte_data(byte_data),
        .auto_en(auto_en), .sw_pec_en(sw_pec_en), .sw_pec(sw_pec),
        .status_clr(status_clr), .pec_out(pec_out),
        .dev_err(dev_err), .crc_err(crc_err), .cfg_err(cfg_err)
    );

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int j = 7; j >= 0; j--) begin
            logic fb = r[7] ^ d[j];
            r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic st, input logic rx, input logic [7:0] d, input logic en);
        txn_start = st; byte_vld = 1'b1; byte_rx = rx; byte_data = d; txn_end = en;
        @(negedge clk);
        txn_start = 1'b0; byte_vld = 1'b0; byte_rx = 1'b0; txn_end = 1'b0;
    endtask

    task automatic clear_all();
        status_clr = 3'b111;
        @(negedge clk);
        status_clr = 3'b000;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] c;
        logic [7:0] p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        auto_en = 1'b1;
        #1;
        // R10 reset state
        chk("R10 pec_out", pec_out, 8'h00);
        chk("R10 flags", {5'd0, cfg_err, crc_err, dev_err}, 8'h00);

        // table walk: R1 R3 R4 R6 R7
        foreach (VECS[n]) begin
            vec_t v = VECS[n];
            auto_en = v.auto_m;
            sw_pec  = v.sw;
            clear_all();
            c = 8'h00;
            for (int i = 0; i < int'(v.nb); i++) begin
                logic [7:0] b = v.bytes[31-8*i -: 8];
                if (v.rxm[i] && i == int'(v.nb) - 1) b = c ^ (v.bad ? 8'h5A : 8'h00);
                send(i == 0, v.rxm[i], b, 1'b0);
                c = ref_crc(c, b);
            end
            // R1 R3 accumulate across direction change; R4 manual pass-through
            chk(v.auto_m ? "R1/R3 pec_out" : "R4 pec_out", pec_out, v.auto_m ? c : v.sw);
            txn_end = 1'b1;
            @(negedge clk);
            txn_end = 1'b0;
            p = {7'd0, v.auto_m & v.rxm[int'(v.nb) - 1] & v.bad};
            // R6 error flags on bad read; R7 none otherwise
            chk("R6/R7 crc_err", {7'd0, crc_err}, p);
            chk("R6/R7 dev_err", {7'd0, dev_err}, p);
        end

        auto_en = 1'b1;
        sw_pec  = 8'h00;
        clear_all();
        // R1 known values
        send(1'b1, 1'b0, 8'h01, 1'b0);
        chk("R1 crc(01)", pec_out, 8'h07);
        send(1'b1, 1'b0, 8'hFF, 1'b0);
        chk("R1 crc(FF)", pec_out, 8'hF3);

        // R2 start pulse alone clears
        send(1'b1, 1'b0, 8'h12, 1'b0);
        send(1'b0, 1'b0, 8'h34, 1'b0);
        txn_start = 1'b1;
        @(negedge clk);
        txn_start = 1'b0;
        chk("R2 cleared", pec_out, 8'h00);

        // R5 sw_pec ignored in auto mode
        send(1'b1, 1'b0, 8'hA5, 1'b0);
        chk("R5 pec_out", pec_out, ref_crc(8'h00, 8'hA5));
        sw_pec = 8'hFF;
        #1;
        chk("R5 pec_out after sw_pec change", pec_out, ref_crc(8'h00, 8'hA5));

        // R6 final byte on same cycle as txn_end, good then bad
        c = ref_crc(ref_crc(8'h00, 8'hA0), 8'h42);
        send(1'b1, 1'b0, 8'hA0, 1'b0);
        send(1'b0, 1'b1, 8'h42, 1'b0);
        send(1'b0, 1'b1, c, 1'b1);
        chk("R6 same-cycle good crc_err", {7'd0, crc_err}, 8'h00);
        send(1'b1, 1'b0, 8'hA0, 1'b0);
        send(1'b0, 1'b1, 8'h42, 1'b0);
        send(1'b0, 1'b1, c ^ 8'h01, 1'b1);
        chk("R6 same-cycle bad crc_err", {7'd0, crc_err}, 8'h01);
        chk("R6 same-cycle bad dev_err", {7'd0, dev_err}, 8'h01);

        // R9 sticky through a good read, selective clear
        send(1'b1, 1'b0, 8'hA0, 1'b0);
        send(1'b0, 1'b1, ref_crc(8'h00, 8'hA0), 1'b1);
        chk("R9 dev_err sticky", {7'd0, dev_err}, 8'h01);
        status_clr = 3'b010;
        @(negedge clk);
        status_clr = 3'b000;
        chk("R9 crc_err cleared", {7'd0, crc_err}, 8'h00);
        chk("R9 dev_err kept", {7'd0, dev_err}, 8'h01);

        // R8 sw_pec_en alone does nothing
        auto_en = 1'b0;
        sw_pec_en = 1'b1;
        @(negedge clk);
        sw_pec_en = 1'b0;
        chk("R8 no cfg_err in manual", {7'd0, cfg_err}, 8'h00);
        // R8 conflict with simultaneous clear; R9 set wins
        auto_en = 1'b1;
        sw_pec_en = 1'b1;
        status_clr = 3'b100;
        @(negedge clk);
        sw_pec_en = 1'b0;
        status_clr = 3'b000;
        chk("R8/R9 cfg_err set wins", {7'd0, cfg_err}, 8'h01);
        status_clr = 3'b100;
        @(negedge clk);
        status_clr = 3'b000;
        chk("R9 cfg_err cleared", {7'd0, cfg_err}, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule